// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a direct-mapped data cache placed between one processor port and one word-wide memory port. It holds a tag, a line-present bit, a dirty bit and one valid bit for each word of every line. It runs line fills, line write-backs and single-word write-throughs on the memory side. Two static mode inputs choose how writes are treated. `hit_mode` picks what a write hit does, and `miss_mode` picks one of four write-miss treatments. Each miss treatment is a distinct mix of three choices: whether the line is fetched, whether it is allocated, and whether it is invalidated.

Because a line can be allocated without being fetched, a word can be absent from a line whose tag matches. A read of such a word fetches the line and merges it, and any word written locally is kept. Addresses are word addresses, split from high to low into tag, line index and word offset. The processor issues one request at a time and sees a one-cycle completion pulse.

Top module: `wpol_cache`

## Requirements
- R1: After reset `cpu_ready` is 1, `mem_req` is 0, and every line is absent, so the first read of any address fetches its line from memory.
- R2: A request is taken on a clock edge where `cpu_valid` and `cpu_ready` are both 1. `cpu_ready` then stays 0 until `cpu_done` has pulsed for one cycle, with `cpu_rdata` valid in that cycle for reads. `cpu_ready` is 1 in the cycle after the pulse.
- R3: A memory beat completes on an edge where `mem_req` and `mem_gnt` are both 1, with read data sampled from `mem_rdata` in that cycle. While a beat waits for its grant, `mem_addr`, `mem_we` and `mem_wdata` hold still.
- R4: A read whose tag matches and whose word is valid returns the cached word with no memory traffic.
- R5: A read that misses fetches the whole line, one beat per word in ascending offset order, then returns the addressed word.
- R6: With `hit_mode`=0 (write-through), a write hit updates the cache and issues exactly one memory write of that word.
- R7: With `hit_mode`=1 (write-back), a write hit causes no memory traffic and marks the line dirty. Before a dirty line is replaced, each of its valid words is written back in ascending offset order, and invalid words are skipped.
- R8: With `miss_mode`=0 (fetch-on-write), a write miss fills the line from memory, merges the written word, and then follows the hit policy. Later reads of the other words of the line hit.
- R9: With `miss_mode`=1 (write-validate), a write miss installs the tag with no memory read, and only the written word is valid. A later read of another word of the line fetches the line and keeps the written word.
- R10: With `miss_mode`=2 (write-around), a write miss writes the word to memory and leaves the cache unchanged, so the resident line still hits.
- R11: With `miss_mode`=3 (write-invalidate), a write miss writes the word to memory and marks the indexed line absent. If that line is dirty, it is written back first.
- R12: The mode inputs are sampled only when a request is accepted. A change made while a request is in progress does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_mode | input | 1 | 0 write-through, 1 write-back |
| miss_mode | input | 2 | 0 fetch-on-write, 1 write-validate, 2 write-around, 3 write-invalidate |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid while cpu_done is 1 |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | DATA_W | Write beat data |
| mem_gnt | input | 1 | Memory takes the beat in this cycle |
| mem_rdata | input | DATA_W | Read beat data, valid with mem_gnt |

## Verification
The bench builds the cache with 10 address bits, 4 lines of 4 words and 32-bit data. With only four lines, an address 16 words away lands on the same line with a different tag, so evictions, conflicting write misses and write-backs of partly valid lines are easy to produce. The memory model withholds its grant one cycle in three, so stalls fall inside fills and write-backs. It also logs the address of every beat, so the order of beats and the skipping of invalid words can be checked at the memory port.

// File: rtl/wpol_pkg.sv
package wpol_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DECIDE, ST_WBACK, ST_ALLOC, ST_FILL, ST_INVAL, ST_WTHRU, ST_DONE
   } wpol_state_e;

   typedef enum logic [1:0] {
      MISS_FETCH    = 2'd0,
      MISS_VALIDATE = 2'd1,
      MISS_AROUND   = 2'd2,
      MISS_INVAL    = 2'd3
   } wpol_miss_e;
endpackage

// File: rtl/wpol_store.sv
module wpol_store #(
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 4,
   parameter int TAG_W      = 5,
   localparam int IDX_W     = $clog2(LINES),
   localparam int OFF_W     = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [OFF_W-1:0]  off,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fill_en,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              inval_en,
   input  logic              set_dirty,
   input  logic              clr_dirty,
   output logic [TAG_W-1:0]  tag_o,
   output logic              present_o,
   output logic              dirty_o,
   output logic [LINE_WORDS-1:0] wvalid_o,
   output logic [DATA_W-1:0] word_o
);
   logic [LINES-1:0]      present_all;
   logic [LINES-1:0]      dirty_all;
   logic [TAG_W-1:0]      tag_all    [LINES];
   logic [LINE_WORDS-1:0] wvalid_all [LINES];
   logic [DATA_W-1:0]     word_all   [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic                  sel;
      logic                  present_q;
      logic                  dirty_q;
      logic [TAG_W-1:0]      tag_q;
      logic [LINE_WORDS-1:0] wvalid_q;
      logic [DATA_W-1:0]     data_q [LINE_WORDS];

      assign sel = (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present_q <= 1'b0;
            dirty_q   <= 1'b0;
            wvalid_q  <= '0;
         end else if (sel) begin
            if (alloc_en) begin
               present_q <= 1'b1;
               dirty_q   <= 1'b0;
               wvalid_q  <= '0;
            end else if (inval_en) begin
               present_q <= 1'b0;
               dirty_q   <= 1'b0;
               wvalid_q  <= '0;
            end else begin
               if (wr_en || fill_en) wvalid_q[off] <= 1'b1;
               if (set_dirty)      dirty_q <= 1'b1;
               else if (clr_dirty) dirty_q <= 1'b0;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (sel && alloc_en) tag_q <= alloc_tag;
         if (sel && wr_en) data_q[off] <= wr_data;
         else if (sel && fill_en && !wvalid_q[off]) data_q[off] <= fill_data;
      end

      assign present_all[g] = present_q;
      assign dirty_all[g]   = dirty_q;
      assign tag_all[g]     = tag_q;
      assign wvalid_all[g]  = wvalid_q;
      assign word_all[g]    = data_q[off];
   end

   assign present_o = present_all[idx];
   assign dirty_o   = dirty_all[idx];
   assign tag_o     = tag_all[idx];
   assign wvalid_o  = wvalid_all[idx];
   assign word_o    = word_all[idx];
endmodule

// File: rtl/wpol_ctrl.sv
module wpol_ctrl
   import wpol_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 4,
   localparam int IDX_W     = $clog2(LINES),
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_mode,
   input  logic [1:0]        miss_mode,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   // storage side
   output logic [IDX_W-1:0]  s_idx,
   output logic [OFF_W-1:0]  s_off,
   output logic              s_wr_en,
   output logic [DATA_W-1:0] s_wr_data,
   output logic              s_fill_en,
   output logic              s_alloc_en,
   output logic [TAG_W-1:0]  s_alloc_tag,
   output logic              s_inval_en,
   output logic              s_set_dirty,
   output logic              s_clr_dirty,
   input  logic [TAG_W-1:0]  s_tag,
   input  logic              s_present,
   input  logic              s_dirty,
   input  logic [LINE_WORDS-1:0] s_wvalid,
   input  logic [DATA_W-1:0] s_word
);
   wpol_state_e       state_q, state_d;
   logic [OFF_W-1:0]  beat_q;
   logic              beat_adv;
   logic              req_we_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic              wback_q;
   wpol_miss_e        miss_q;
   logic [DATA_W-1:0] rdata_q;
   logic              cap_rd;

   logic [TAG_W-1:0]  r_tag;
   logic [IDX_W-1:0]  r_idx;
   logic [OFF_W-1:0]  r_off;
   logic              tag_hit, need_evict, last_beat;

   assign r_tag      = req_addr_q[ADDR_W-1 -: TAG_W];
   assign r_idx      = req_addr_q[OFF_W +: IDX_W];
   assign r_off      = req_addr_q[OFF_W-1:0];
   assign tag_hit    = s_present && (s_tag == r_tag);
   assign need_evict = s_present && s_dirty;
   assign last_beat  = &beat_q;

   always_comb begin
      state_d     = state_q;
      beat_adv    = 1'b0;
      cap_rd      = 1'b0;
      cpu_ready   = 1'b0;
      cpu_done    = 1'b0;
      mem_req     = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = req_addr_q;
      mem_wdata   = req_wdata_q;
      s_idx       = r_idx;
      s_off       = r_off;
      s_wr_en     = 1'b0;
      s_wr_data   = req_wdata_q;
      s_fill_en   = 1'b0;
      s_alloc_en  = 1'b0;
      s_alloc_tag = r_tag;
      s_inval_en  = 1'b0;
      s_set_dirty = 1'b0;
      s_clr_dirty = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            cpu_ready = 1'b1;
            if (cpu_valid) state_d = ST_DECIDE;
         end
         ST_DECIDE: begin
            if (!req_we_q) begin
               if (tag_hit && s_wvalid[r_off]) begin
                  cap_rd  = 1'b1;
                  state_d = ST_DONE;
               end else if (tag_hit)  state_d = ST_FILL;
               else if (need_evict)   state_d = ST_WBACK;
               else                   state_d = ST_ALLOC;
            end else if (tag_hit) begin
               s_wr_en = 1'b1;
               if (wback_q) begin
                  s_set_dirty = 1'b1;
                  state_d     = ST_DONE;
               end else begin
                  state_d = ST_WTHRU;
               end
            end else begin
               unique case (miss_q)
                  MISS_FETCH, MISS_VALIDATE: state_d = need_evict ? ST_WBACK : ST_ALLOC;
                  MISS_AROUND:               state_d = ST_WTHRU;
                  MISS_INVAL:                state_d = need_evict ? ST_WBACK : ST_INVAL;
               endcase
            end
         end
         ST_WBACK: begin
            s_off     = beat_q;
            mem_req   = s_wvalid[beat_q];
            mem_we    = 1'b1;
            mem_addr  = {s_tag, r_idx, beat_q};
            mem_wdata = s_word;
            beat_adv  = !s_wvalid[beat_q] || mem_gnt;
            if (beat_adv && last_beat) begin
               s_clr_dirty = 1'b1;
               state_d     = (req_we_q && miss_q == MISS_INVAL) ? ST_INVAL : ST_ALLOC;
            end
         end
         ST_ALLOC: begin
            s_alloc_en = 1'b1;
            state_d    = (!req_we_q || miss_q == MISS_FETCH) ? ST_FILL : ST_DECIDE;
         end
         ST_FILL: begin
            s_off     = beat_q;
            mem_req   = 1'b1;
            mem_addr  = {r_tag, r_idx, beat_q};
            s_fill_en = mem_gnt;
            beat_adv  = mem_gnt;
            if (mem_gnt && last_beat) state_d = ST_DECIDE;
         end
         ST_INVAL: begin
            s_inval_en = 1'b1;
            state_d    = ST_WTHRU;
         end
         ST_WTHRU: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_gnt) state_d = ST_DONE;
         end
         ST_DONE: begin
            cpu_done = 1'b1;
            state_d  = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         beat_q      <= '0;
         req_we_q    <= 1'b0;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         wback_q     <= 1'b0;
         miss_q      <= MISS_FETCH;
         rdata_q     <= '0;
      end else begin
         state_q <= state_d;
         if (beat_adv) beat_q <= beat_q + 1'b1;
         if (cap_rd)   rdata_q <= s_word;
         if (state_q == ST_IDLE && cpu_valid) begin
            req_we_q    <= cpu_we;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            wback_q     <= hit_mode;
            miss_q      <= wpol_miss_e'(miss_mode);
         end
      end
   end

   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/wpol_cache.sv
module wpol_cache #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_mode,
   input  logic [1:0]        miss_mode,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(LINES);
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   initial begin
      assert (LINES >= 2 && (1 << IDX_W) == LINES)
         else $fatal(1, "LINES must be a power of two, at least 2");
      assert (LINE_WORDS >= 2 && (1 << OFF_W) == LINE_WORDS)
         else $fatal(1, "LINE_WORDS must be a power of two, at least 2");
      assert (TAG_W >= 1) else $fatal(1, "ADDR_W too small for geometry");
   end

   logic [IDX_W-1:0]      s_idx;
   logic [OFF_W-1:0]      s_off;
   logic                  s_wr_en, s_fill_en, s_alloc_en, s_inval_en;
   logic                  s_set_dirty, s_clr_dirty, s_present, s_dirty;
   logic [DATA_W-1:0]     s_wr_data, s_word;
   logic [TAG_W-1:0]      s_alloc_tag, s_tag;
   logic [LINE_WORDS-1:0] s_wvalid;

   wpol_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .hit_mode(hit_mode), .miss_mode(miss_mode),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
      .s_idx(s_idx), .s_off(s_off), .s_wr_en(s_wr_en), .s_wr_data(s_wr_data),
      .s_fill_en(s_fill_en), .s_alloc_en(s_alloc_en), .s_alloc_tag(s_alloc_tag),
      .s_inval_en(s_inval_en), .s_set_dirty(s_set_dirty), .s_clr_dirty(s_clr_dirty),
      .s_tag(s_tag), .s_present(s_present), .s_dirty(s_dirty),
      .s_wvalid(s_wvalid), .s_word(s_word)
   );

   wpol_store #(
      .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .idx(s_idx), .off(s_off),
      .wr_en(s_wr_en), .wr_data(s_wr_data), .fill_en(s_fill_en),
      .fill_data(mem_rdata), .alloc_en(s_alloc_en), .alloc_tag(s_alloc_tag),
      .inval_en(s_inval_en), .set_dirty(s_set_dirty), .clr_dirty(s_clr_dirty),
      .tag_o(s_tag), .present_o(s_present), .dirty_o(s_dirty),
      .wvalid_o(s_wvalid), .word_o(s_word)
   );
endmodule

// File: rtl/wpol_cache_chk.sv
module wpol_cache_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_gnt
);
   // R2: the controller makes no memory traffic while idle
   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   // R2: an accepted request makes the controller busy
   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready |=> !cpu_ready);

   // R2: completion is a single pulse followed by readiness
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done && cpu_ready);

   // R2: completion never coincides with readiness
   p_done_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_ready);

   // R3: a beat waiting for grant keeps its request and address
   p_hold_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R3: write data holds while a write beat waits
   p_hold_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && !mem_gnt |=> $stable(mem_wdata));
endmodule

bind wpol_cache wpol_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
   .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
);

// File: tb/wpol_cache_test.sv
module wpol_cache_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 32;
   localparam int NL = 4;
   localparam int LW = 4;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_mode = 1'b0;
   logic [1:0]    miss_mode = 2'd0;
   logic          cpu_valid = 1'b0;
   logic          cpu_ready;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_gnt = 1'b0;
   logic [DW-1:0] mem_rdata;

   int checks = 0;
   int fails  = 0;
   int rd_beats = 0;
   int wr_beats = 0;
   int cyc = 0;
   logic [AW-1:0] rlog [64];
   logic [AW-1:0] wlog [64];
   logic [DW-1:0] mem  [1 << AW];

   always #(CLK_PERIOD/2) clk = ~clk;

   wpol_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .LINE_WORDS(LW)) uut (
      .clk(clk), .rst_n(rst_n), .hit_mode(hit_mode), .miss_mode(miss_mode),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] init_word(input int a);
      return {8'(a), 8'hC3, 6'd0, 10'(a)};
   endfunction

   initial for (int i = 0; i < (1 << AW); i++) mem[i] = init_word(i);

   assign mem_rdata = mem[mem_addr];

   // memory model: beat on req && gnt, logged in order
   always @(posedge clk) begin
      if (mem_req && mem_gnt) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wlog[wr_beats % 64] <= mem_addr;
            wr_beats <= wr_beats + 1;
         end else begin
            rlog[rd_beats % 64] <= mem_addr;
            rd_beats <= rd_beats + 1;
         end
      end
   end

   // grant withheld one cycle in three
   always @(negedge clk) begin
      cyc     <= cyc + 1;
      mem_gnt <= (cyc % 3) != 2;
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic flip, output logic [DW-1:0] rd);
      logic busy_ok;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      while (!cpu_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
      if (flip) hit_mode = ~hit_mode;
      busy_ok = 1'b1;
      while (!cpu_done) begin
         if (cpu_ready) busy_ok = 1'b0;
         @(negedge clk);
      end
      rd = cpu_rdata;
      @(negedge clk);
      chk("R2 busy until done", 32'(busy_ok), 32'd1);
      chk("R2 ready after done", 32'(cpu_ready), 32'd1);
   endtask

   task automatic set_mode(input logic h, input logic [1:0] m);
      @(negedge clk);
      hit_mode = h; miss_mode = m;
   endtask

   task automatic t_reset_and_fill;
      logic [DW-1:0] rd;
      int r0;
      chk("R1 ready after reset", 32'(cpu_ready), 32'd1);
      chk("R1 no mem request after reset", 32'(mem_req), 32'd0);
      set_mode(1'b0, 2'd0);
      r0 = rd_beats;
      do_req(1'b0, 10'h040, '0, 1'b0, rd);
      chk("R1 first read misses: 4 read beats", 32'(rd_beats - r0), 32'd4);
      chk("R5 miss returns memory word", rd, init_word('h40));
      for (int i = 0; i < LW; i++)
         chk("R5 fill beat order", 32'(rlog[(r0 + i) % 64]), 32'('h40 + i));
   endtask

   task automatic t_read_hit;
      logic [DW-1:0] rd;
      int r0, w0;
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b0, 10'h042, '0, 1'b0, rd);
      chk("R4 hit data", rd, init_word('h42));
      chk("R4 hit makes no memory traffic", 32'(rd_beats - r0 + wr_beats - w0), 32'd0);
   endtask

   task automatic t_write_through_hit;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b0, 2'd0);
      w0 = wr_beats;
      do_req(1'b1, 10'h041, 32'hAAAA_0041, 1'b0, rd);
      chk("R6 one write beat", 32'(wr_beats - w0), 32'd1);
      chk("R6 memory holds word", mem['h41], 32'hAAAA_0041);
      r0 = rd_beats;
      do_req(1'b0, 10'h041, '0, 1'b0, rd);
      chk("R6 cache updated", rd, 32'hAAAA_0041);
      chk("R6 read back hits", 32'(rd_beats - r0), 32'd0);
   endtask

   task automatic t_write_back_evict;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b1, 2'd0);
      w0 = wr_beats;
      do_req(1'b1, 10'h042, 32'hBBBB_0042, 1'b0, rd);
      chk("R7 write hit makes no write beat", 32'(wr_beats - w0), 32'd0);
      chk("R7 memory stale after write hit", mem['h42], init_word('h42));
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b0, 10'h052, '0, 1'b0, rd);
      chk("R7 eviction writes 4 beats", 32'(wr_beats - w0), 32'd4);
      for (int i = 0; i < LW; i++)
         chk("R7 eviction order", 32'(wlog[(w0 + i) % 64]), 32'('h40 + i));
      chk("R7 dirty word reached memory", mem['h42], 32'hBBBB_0042);
      chk("R7 new line filled", 32'(rd_beats - r0), 32'd4);
      chk("R7 conflicting read data", rd, init_word('h52));
   endtask

   task automatic t_fetch_on_write;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b1, 2'd0);
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b1, 10'h065, 32'hCCCC_0065, 1'b0, rd);
      chk("R8 write miss fills line", 32'(rd_beats - r0), 32'd4);
      chk("R8 no write beat under write-back", 32'(wr_beats - w0), 32'd0);
      r0 = rd_beats;
      do_req(1'b0, 10'h067, '0, 1'b0, rd);
      chk("R8 other word hits", 32'(rd_beats - r0), 32'd0);
      chk("R8 other word data", rd, init_word('h67));
      do_req(1'b0, 10'h065, '0, 1'b0, rd);
      chk("R8 written word merged", rd, 32'hCCCC_0065);
   endtask

   task automatic t_write_validate;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b1, 2'd1);
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b1, 10'h08A, 32'hDDDD_008A, 1'b0, rd);
      chk("R9 no memory traffic on write miss", 32'(rd_beats - r0 + wr_beats - w0), 32'd0);
      do_req(1'b0, 10'h08A, '0, 1'b0, rd);
      chk("R9 written word hits", rd, 32'hDDDD_008A);
      chk("R9 written word hit needs no read", 32'(rd_beats - r0), 32'd0);
      do_req(1'b0, 10'h088, '0, 1'b0, rd);
      chk("R9 invalid word triggers fill", 32'(rd_beats - r0), 32'd4);
      chk("R9 filled word data", rd, init_word('h88));
      r0 = rd_beats;
      do_req(1'b0, 10'h08A, '0, 1'b0, rd);
      chk("R9 local word kept through fill", rd, 32'hDDDD_008A);
      chk("R9 kept word hits", 32'(rd_beats - r0), 32'd0);
      // partly valid dirty line: only its valid word is written back
      do_req(1'b1, 10'h0CD, 32'hEEEE_00CD, 1'b0, rd);
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b1, 10'h0DC, 32'hFFFF_00DC, 1'b0, rd);
      chk("R7 only valid word written back", 32'(wr_beats - w0), 32'd1);
      chk("R7 written-back address", 32'(wlog[w0 % 64]), 32'h0CD);
      chk("R9 partial eviction data", mem['hCD], 32'hEEEE_00CD);
      do_req(1'b0, 10'h0DC, '0, 1'b0, rd);
      chk("R9 new validated word", rd, 32'hFFFF_00DC);
      chk("R9 no reads for validated line", 32'(rd_beats - r0), 32'd0);
   endtask

   task automatic t_write_around;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b0, 2'd2);
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b1, 10'h074, 32'h1111_0074, 1'b0, rd);
      chk("R10 one write beat", 32'(wr_beats - w0), 32'd1);
      chk("R10 memory updated", mem['h74], 32'h1111_0074);
      do_req(1'b0, 10'h065, '0, 1'b0, rd);
      chk("R10 resident line still hits", 32'(rd_beats - r0), 32'd0);
      chk("R10 resident data intact", rd, 32'hCCCC_0065);
   endtask

   task automatic t_write_invalidate;
      logic [DW-1:0] rd;
      int r0, w0;
      set_mode(1'b1, 2'd3);
      r0 = rd_beats; w0 = wr_beats;
      do_req(1'b1, 10'h075, 32'h2222_0075, 1'b0, rd);
      chk("R11 dirty write-back plus word", 32'(wr_beats - w0), 32'd5);
      chk("R11 word written last", 32'(wlog[(w0 + 4) % 64]), 32'h075);
      chk("R11 dirty data saved", mem['h65], 32'hCCCC_0065);
      chk("R11 word in memory", mem['h75], 32'h2222_0075);
      chk("R11 no reads", 32'(rd_beats - r0), 32'd0);
      do_req(1'b0, 10'h065, '0, 1'b0, rd);
      chk("R11 line was invalidated", 32'(rd_beats - r0), 32'd4);
      chk("R11 refetched data", rd, 32'hCCCC_0065);
   endtask

   task automatic t_mode_sampling;
      logic [DW-1:0] rd;
      int w0;
      set_mode(1'b0, 2'd0);
      w0 = wr_beats;
      do_req(1'b1, 10'h066, 32'h3333_0066, 1'b1, rd);
      chk("R12 sampled write-through kept", 32'(wr_beats - w0), 32'd1);
      chk("R12 memory written", mem['h66], 32'h3333_0066);
      set_mode(1'b0, 2'd0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_fill();
      t_read_hit();
      t_write_through_hit();
      t_write_back_evict();
      t_fetch_on_write();
      t_write_validate();
      t_write_around();
      t_write_invalidate();
      t_mode_sampling();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule